// File: doc/BRIEF.md
# Hybrid Table-CORDIC Sine/Cosine Generator

This block is a pipelined phase-to-amplitude converter for a digital oscillator. It takes a phase word of `AW` bits, where the full word spans one turn, and returns a sine sample and a cosine sample of `FGO` bits each. No multiplier and no large table are used. The three leading phase bits give the octant. The bits below them are folded into the first octant, which is 0 to π/4. In odd octants the fold mirrors the angle.

The first octant is cut into 2^(FS-2) equal wedges. A small pair of constant tables holds the point at the centre of each wedge, pre-scaled by the inverse of the rotation gain. The signed offset from the wedge centre is then removed by rotation stages with indices FS through LS. Each stage is a shift-and-add. Finally, the octant bits, delayed to match the pipeline, swap and negate the result into the correct quadrant. Moving FS up enlarges the tables and shortens the pipeline. Moving it down does the reverse.

A phase word can be presented on every cycle, and each word produces one sample pair a fixed number of cycles later. Parameters select rounding or truncation of the internal width, two's-complement or offset-binary output, an optional output register, and whether each of the two outputs is built.

Top module: `hybrid_sincos`

## Requirements
- R1: While `rst_n` is low, both outputs are zero. After release, both outputs stay zero until the first phase presented after release reaches the output.
- R2: With the output register present, the samples for a phase that is on `phase_i` at a rising edge appear after exactly LS−FS+3 rising edges (15 with the defaults). A phase held steady gives steady outputs.
- R3: In two's-complement mode, `cos_o` equals round(32767·cos(2π·phase/2^AW)) to within ±2 LSB for any phase (FGO = 16).
- R4: In two's-complement mode, `sin_o` equals round(32767·sin(2π·phase/2^AW)) to within ±2 LSB for any phase.
- R5: The three most significant phase bits select the octant. The first phase, the last phase and the middle phase of each of the eight octants meet R3 and R4. The cosine is never below −2 in octants 0, 1, 6 and 7, and never above +2 in the other octants. The sine is never below −2 in octants 0 to 3, and never above +2 in octants 4 to 7.
- R6: Phase bits AW−4 down to AW−FS−1 select one of 2^(FS−2) wedges of an octant. Phases on both sides of every wedge boundary, in even and in odd octants, meet R3 and R4.
- R7: The outputs are clamped to ±(2^(FGO−1)−1) and never take the code −2^(FGO−1), which is 16'h8000 with the defaults.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| phase_i | input | AW | Phase word; the full range is one turn |
| cos_o | output | FGO | Cosine sample |
| sin_o | output | FGO | Sine sample |

## Verification
The hardest cases to reach are the phases that sit exactly on an octant or wedge edge. There, the mirrored residual in an odd octant runs one step past the end of its wedge. Uniform random phases of 20 bits almost never land on these points. The stimulus therefore mixes a seeded random stream with directed phases at every octant start and end, and at every wedge boundary ±1 in both even and odd octants. It also holds the phase steady and then steps it by a quarter turn, which exposes any error in the pipeline latency.

// File: rtl/hybrid_sincos.sv
`timescale 1ns/1ps
module hybrid_sincos #(
  parameter int AW         = 20,
  parameter int FS         = 4,
  parameter int LS         = 16,
  parameter int FGO        = 16,
  parameter int XY         = 21,
  parameter int ZFRAC      = 4,
  parameter bit ROUND_OUT  = 1'b1,
  parameter bit SIGNED_OUT = 1'b1,
  parameter bit OUT_REG    = 1'b1,
  parameter bit COS_EN     = 1'b1,
  parameter bit SIN_EN     = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  phase_i,
  output logic [FGO-1:0] cos_o,
  output logic [FGO-1:0] sin_o
);

  localparam int  WB   = FS - 2;
  localparam int  NW   = 1 << WB;
  localparam int  RW   = AW - FS - 1;
  localparam int  NST  = LS - FS + 1;
  localparam int  ZW0  = RW + ZFRAC + 2;
  localparam int  SH   = XY - FGO - 1;
  localparam int  OMAX = (1 << (FGO - 1)) - 1;
  localparam real PI   = 3.14159265358979323846;

  function automatic real inv_gain();
    real g;
    g = 1.0;
    for (int i = FS; i <= LS; i++) g = g * $sqrt(1.0 + 2.0 ** (-2.0 * i));
    return 1.0 / g;
  endfunction

  localparam real AMP = real'(OMAX) * (2.0 ** SH) * inv_gain();

  // wedge-centre start points, sign bit implied zero
  logic [XY-2:0] tab_x [NW];
  logic [XY-2:0] tab_y [NW];

  for (genvar w = 0; w < NW; w++) begin : g_tab
    localparam real CA = (real'(w) + 0.5) * PI / (4.0 * NW);
    localparam int  TX = $rtoi(AMP * $cos(CA) + 0.5);
    localparam int  TY = $rtoi(AMP * $sin(CA) + 0.5);
    assign tab_x[w] = (XY-1)'(TX);
    assign tab_y[w] = (XY-1)'(TY);
  end

  // octant fold and wedge split
  logic [2:0]            oct;
  logic [AW-4:0]         th, thr;
  logic [WB-1:0]         wsel;
  logic [RW-1:0]         res;
  logic signed [ZW0-1:0] z0;

  assign oct  = phase_i[AW-1 -: 3];
  assign th   = phase_i[AW-4:0];
  assign thr  = oct[0] ? ~th : th;
  assign wsel = thr[AW-4 -: WB];
  assign res  = thr[RW-1:0];
  assign z0   = $signed({2'b00, res, {ZFRAC{1'b0}}})
              + (oct[0] ? ZW0'(1 << ZFRAC) : ZW0'(0))
              - ZW0'(1 << (RW - 1 + ZFRAC));

  logic signed [XY-1:0]  x0_q, y0_q;
  logic signed [ZW0-1:0] z0_q;
  logic [2:0]            o0_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x0_q <= '0;
      y0_q <= '0;
      z0_q <= '0;
      o0_q <= '0;
    end else begin
      x0_q <= $signed({1'b0, tab_x[wsel]});
      y0_q <= $signed({1'b0, tab_y[wsel]});
      z0_q <= z0;
      o0_q <= oct;
    end
  end

  // rotation stages FS..LS
  for (genvar k = 0; k < NST; k++) begin : g_stg
    localparam int I  = FS + k;
    localparam int WI = ZW0 - k;

    logic signed [XY-1:0] xi, yi, xq, yq;
    logic [2:0]           oi, oq;
    logic                 zneg;

    if (k == 0) begin : g_in0
      assign xi = x0_q;
      assign yi = y0_q;
      assign oi = o0_q;
    end else begin : g_in
      assign xi = g_stg[k-1].xq;
      assign yi = g_stg[k-1].yq;
      assign oi = g_stg[k-1].oq;
    end

    if (k < NST - 1) begin : g_z
      localparam int AT  = $rtoi($atan(2.0 ** (-I)) * (2.0 ** (AW + ZFRAC)) / (2.0 * PI) + 0.5);
      localparam int ZQW = (k == NST - 2) ? 1 : WI - 1;
      logic signed [WI-1:0]  zin;
      logic signed [WI-2:0]  zn;
      logic signed [ZQW-1:0] zq;

      if (k == 0) begin : g_zs
        assign zin = z0_q;
      end else begin : g_zp
        assign zin = g_stg[k-1].g_z.zq;
      end

      assign zneg = zin[WI-1];
      assign zn   = (WI-1)'(zneg ? zin + WI'(AT) : zin - WI'(AT));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) zq <= '0;
        else        zq <= zn[WI-2 -: ZQW];
      end
    end else begin : g_zl
      if (k == 0) begin : g_zs
        assign zneg = z0_q[ZW0-1];
      end else begin : g_zp
        assign zneg = g_stg[k-1].g_z.zq[0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        xq <= '0;
        yq <= '0;
        oq <= '0;
      end else begin
        xq <= zneg ? xi + (yi >>> I) : xi - (yi >>> I);
        yq <= zneg ? yi - (xi >>> I) : yi + (xi >>> I);
        oq <= oi;
      end
    end
  end

  // width reduction with clamp
  function automatic logic signed [FGO-1:0] shrink(input logic signed [XY-1:0] v);
    logic signed [XY:0]    t;
    logic signed [XY-SH:0] q;
    t = {v[XY-1], v} + (ROUND_OUT ? (XY+1)'(1 << (SH - 1)) : (XY+1)'(0));
    q = t[XY:SH];
    if (q > OMAX)       return FGO'(OMAX);
    else if (q < -OMAX) return FGO'(-OMAX);
    else                return q[FGO-1:0];
  endfunction

  logic signed [FGO-1:0] xr, yr, cv, sv, cm, sm;
  logic [2:0]            of;
  logic                  swp, cneg, sneg;
  logic [FGO-1:0]        cf, sf;

  assign of   = g_stg[NST-1].oq;
  assign xr   = shrink(g_stg[NST-1].xq);
  assign yr   = shrink(g_stg[NST-1].yq);
  assign swp  = of[0] ^ of[1];
  assign cneg = of[2] ^ of[1];
  assign sneg = of[2];
  assign cv   = swp ? yr : xr;
  assign sv   = swp ? xr : yr;
  assign cm   = cneg ? -cv : cv;
  assign sm   = sneg ? -sv : sv;

  logic [FGO-1:0] cfm, sfm;
  assign cfm = SIGNED_OUT ? cm : {~cm[FGO-1], cm[FGO-2:0]};
  assign sfm = SIGNED_OUT ? sm : {~sm[FGO-1], sm[FGO-2:0]};
  assign cf  = COS_EN ? cfm : '0;
  assign sf  = SIN_EN ? sfm : '0;

  if (OUT_REG) begin : g_oreg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cos_o <= '0;
        sin_o <= '0;
      end else begin
        cos_o <= cf;
        sin_o <= sf;
      end
    end
  end else begin : g_ocmb
    assign cos_o = cf;
    assign sin_o = sf;
  end

endmodule

// File: rtl/hybrid_sincos_chk.sv
`timescale 1ns/1ps
module hybrid_sincos_chk #(
  parameter int AW         = 20,
  parameter int FS         = 4,
  parameter int LS         = 16,
  parameter int FGO        = 16,
  parameter bit SIGNED_OUT = 1'b1,
  parameter bit OUT_REG    = 1'b1
) (
  input logic           clk,
  input logic           rst_n,
  input logic [AW-1:0]  phase_i,
  input logic [FGO-1:0] cos_o,
  input logic [FGO-1:0] sin_o
);

  localparam int LAT  = LS - FS + 2 + (OUT_REG ? 1 : 0);
  localparam int OMAX = (1 << (FGO - 1)) - 1;
  localparam logic [FGO-1:0] MINV = {1'b1, {(FGO-1){1'b0}}};

  logic [FGO-1:0]        flip;
  logic signed [FGO-1:0] cs, ss;
  assign flip = SIGNED_OUT ? '0 : MINV;
  assign cs   = cos_o ^ flip;
  assign ss   = sin_o ^ flip;

  logic [AW-1:0] pd [LAT];
  logic [AW-1:0] prev;
  logic          seen;
  int            fill, scnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < LAT; j++) pd[j] <= '0;
      prev <= '0;
      seen <= 1'b0;
      fill <= 0;
      scnt <= 0;
    end else begin
      pd[0] <= phase_i;
      for (int j = 1; j < LAT; j++) pd[j] <= pd[j-1];
      prev <= phase_i;
      seen <= 1'b1;
      if (fill < LAT) fill <= fill + 1;
      if (seen && phase_i == prev) begin
        if (scnt < LAT + 4) scnt <= scnt + 1;
      end else begin
        scnt <= 0;
      end
    end
  end

  logic [2:0] octd;
  assign octd = pd[LAT-1][AW-1 -: 3];

  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cos_o == '0 && sin_o == '0));

  // R2
  hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scnt > LAT + 1) |-> ($stable(cos_o) && $stable(sin_o)));

  // R5
  cos_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill >= LAT) |-> ((octd == 3'd0 || octd == 3'd1 || octd == 3'd6 || octd == 3'd7) ?
                       (cs >= -2) : (cs <= 2)));

  // R5
  sin_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill >= LAT) |-> (!octd[2] ? (ss >= -2) : (ss <= 2)));

  // R3
  zero_phase_peak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill >= LAT && pd[LAT-1] == '0) |-> (cs >= OMAX - 2 && ss <= 2 && ss >= -2));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs != MINV && ss != MINV));

endmodule

bind hybrid_sincos hybrid_sincos_chk #(
  .AW(AW), .FS(FS), .LS(LS), .FGO(FGO), .SIGNED_OUT(SIGNED_OUT), .OUT_REG(OUT_REG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .phase_i(phase_i), .cos_o(cos_o), .sin_o(sin_o)
);

// File: tb/hybrid_sincos_bench.sv
`timescale 1ns/1ps
module hybrid_sincos_bench;

  localparam int  AW   = 20;
  localparam int  FGO  = 16;
  localparam int  FS   = 4;
  localparam int  LS   = 16;
  localparam int  LAT  = LS - FS + 3;
  localparam int  OMAX = 32767;
  localparam real PI   = 3.14159265358979323846;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [AW-1:0]  phase = '0;
  logic [FGO-1:0] cos_w, sin_w;

  always #10 clk = ~clk;

  hybrid_sincos #(.AW(AW), .FS(FS), .LS(LS), .FGO(FGO)) u_hybrid_sincos (
    .clk(clk), .rst_n(rst_n), .phase_i(phase), .cos_o(cos_w), .sin_o(sin_w)
  );

  int            total = 0;
  int            fails = 0;
  int            cyc   = 0;
  logic [AW-1:0] hist [64];
  string         htag [64];

  function automatic int ref_val(logic [AW-1:0] p, bit want_sin);
    real a, v;
    a = 2.0 * PI * real'(p) / (2.0 ** AW);
    v = real'(OMAX) * (want_sin ? $sin(a) : $cos(a));
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(0.5 - v);
  endfunction

  task automatic check(string tag, string what, int act, int exp, int tol);
    total++;
    if (act > exp + tol || act < exp - tol) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(logic [AW-1:0] ph, string tag);
    logic [AW-1:0] p;
    string         t, tc, ts;
    @(negedge clk);
    if (cyc >= LAT) begin
      p  = hist[(cyc - LAT) % 64];
      t  = htag[(cyc - LAT) % 64];
      tc = (t == "RND") ? "R3" : t;
      ts = (t == "RND") ? "R4" : t;
      check(tc, $sformatf("cos @%0h", p), int'($signed(cos_w)), ref_val(p, 1'b0), 2);
      check(ts, $sformatf("sin @%0h", p), int'($signed(sin_w)), ref_val(p, 1'b1), 2);
      if (t == "R7")
        check("R7", $sformatf("most negative code @%0h", p),
              (cos_w == 16'h8000 || sin_w == 16'h8000) ? 1 : 0, 0, 0);
    end else begin
      check("R1", "pipeline fill cos", int'($signed(cos_w)), 0, 0);
      check("R1", "pipeline fill sin", int'($signed(sin_w)), 0, 0);
    end
    phase = ph;
    hist[cyc % 64] = ph;
    htag[cyc % 64] = tag;
    cyc++;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    // R1: outputs held at zero in reset
    repeat (3) begin
      @(negedge clk);
      check("R1", "reset cos", int'(cos_w), 0, 0);
      check("R1", "reset sin", int'(sin_w), 0, 0);
    end
    rst_n = 1'b1;
    hist[0] = '0;
    htag[0] = "R2";
    cyc = 1;

    // R2: latency step from hold at zero to a quarter turn
    repeat (20) step('0, "R2");
    repeat (20) step(AW'(1) << (AW - 2), "R2");

    // R5: octant starts, ends and middles
    for (int o = 0; o < 8; o++) begin
      step(AW'(o) << (AW - 3), "R5");
      step((AW'(o) << (AW - 3)) + AW'(1), "R5");
      step((AW'(o) << (AW - 3)) - AW'(1), "R5");
      step((AW'(o) << (AW - 3)) + (AW'(1) << (AW - 4)), "R5");
    end

    // R6: wedge boundaries in even and odd octants
    for (int o = 0; o < 8; o += 3) begin
      for (int w = 0; w < (1 << (FS - 2)); w++) begin
        step((AW'(o) << (AW - 3)) + (AW'(w) << (AW - FS - 1)), "R6");
        step((AW'(o) << (AW - 3)) + (AW'(w) << (AW - FS - 1)) + AW'(1), "R6");
        step((AW'(o) << (AW - 3)) + (AW'(w) << (AW - FS - 1)) - AW'(1), "R6");
      end
    end

    // R7: peaks in all four directions
    for (int q = 0; q < 4; q++) step(AW'(q) << (AW - 2), "R7");

    // R3 / R4: seeded random phases
    for (int n = 0; n < 3000; n++) step(AW'($urandom()), "RND");

    repeat (LAT) step('0, "R3");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule